// File: doc/BRIEF.md
# Self-Starting Five-Code Cycle Counter

This block is a free-running synchronous counter built from three state bits, named C, B and A from most to least significant. On every rising clock edge it steps to the next code of a fixed five-code loop that does not follow binary order. The registered state is driven straight out as the count, so no output decoding sits after the flip-flops.

Three of the eight 3-bit codes lie outside the loop. Each of them has a fixed successor instead of being left undefined, so a counter that powers up in an unused code always falls back into the loop within two clocks. A test load path can force any code, which makes recovery from each unused code observable. A registered flag reports whether the present code belongs to the loop.

Top module: `cyc5_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next `code_q` is 000 and `legal_q` is 1. `rst` has priority over `load_en`.
- R2: With `rst` and `load_en` low, the loop codes (bit order C,B,A) advance as 000 to 010, 010 to 011, 011 to 101, 101 to 110, and 110 back to 000.
- R3: With `rst` and `load_en` low, code 001 steps to 110.
- R4: With `rst` and `load_en` low, code 100 steps to 010.
- R5: With `rst` and `load_en` low, code 111 steps to 100 and then to 010.
- R6: With `rst` low and `load_en` high at a rising edge, the next `code_q` equals `load_code`. The normal advance does not apply on that edge.
- R7: `legal_q` is 1 in exactly the cycles where `code_q` is one of 000, 010, 011, 101 or 110. It is 0 for 001, 100 and 111.
- R8: From any unused code, with no load or reset, `code_q` is back on a loop code after at most two clock edges.
- R9: Once on the loop and left free-running, `code_q` repeats with a period of exactly five clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| load_en | input | 1 | Test load strobe; forces `load_code` on the next edge |
| load_code | input | 3 | Code to force when `load_en` is high (C,B,A) |
| code_q | output | 3 | Registered state, which is also the count (C,B,A) |
| legal_q | output | 1 | High while `code_q` is a loop code |

## Verification
On every cycle, the assertions check the successor of each of the eight codes, the reset and load outcomes, and whether the legal flag agrees with the present code. Several behaviours can only be shown by the bench's directed scenarios: the five-clock period, the complete two-step escape from 111, the priority of reset over load, and the way a load overrides the advance.

// File: rtl/cyc5_pkg.sv
package cyc5_pkg;
  localparam int CODE_W = 3;
  localparam int LOOP_LEN = 5;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_RESET = 3'b000;
  localparam code_t CODE_L1    = 3'b010;
  localparam code_t CODE_L2    = 3'b011;
  localparam code_t CODE_L3    = 3'b101;
  localparam code_t CODE_L4    = 3'b110;

  localparam int BIT_A = 0;
  localparam int BIT_B = 1;
  localparam int BIT_C = 2;
endpackage

// File: rtl/cyc5_next.sv
module cyc5_next
  import cyc5_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  logic a, b, c;

  always_comb begin
    a = cur[BIT_A];
    b = cur[BIT_B];
    c = cur[BIT_C];
    nxt = '0;
    nxt[BIT_C] = a;
    nxt[BIT_B] = ~b | (~a & ~c);
    nxt[BIT_A] = b & ~c;
  end
endmodule

// File: rtl/cyc5_legal.sv
module cyc5_legal
  import cyc5_pkg::*;
(
  input  code_t code,
  output logic  is_loop
);
  always_comb begin
    unique case (code)
      CODE_RESET, CODE_L1, CODE_L2, CODE_L3, CODE_L4: is_loop = 1'b1;
      default:                                        is_loop = 1'b0;
    endcase
  end
endmodule

// File: rtl/cyc5_counter.sv
module cyc5_counter
  import cyc5_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_code,
  output logic [CODE_W-1:0] code_q,
  output logic              legal_q
);
  code_t state_q;
  code_t step_d;
  code_t state_d;
  logic  legal_d;

  cyc5_next u_next (
    .cur (state_q),
    .nxt (step_d)
  );

  always_comb begin
    if (load_en) state_d = load_code;
    else         state_d = step_d;
  end

  cyc5_legal u_legal (
    .code    (state_d),
    .is_loop (legal_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CODE_RESET;
      legal_q <= 1'b1;
    end else begin
      state_q <= state_d;
      legal_q <= legal_d;
    end
  end

  assign code_q = state_q;
endmodule

// File: rtl/cyc5_counter_chk.sv
module cyc5_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_en,
  input logic [2:0] load_code,
  input logic [2:0] code_q,
  input logic       legal_q
);
  logic run;
  assign run = !load_en;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (code_q == 3'b000 && legal_q)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst) load_en |=> code_q == $past(load_code)); // R6
  AST_STEP_000: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b000) |=> code_q == 3'b010); // R2
  AST_STEP_010: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b010) |=> code_q == 3'b011); // R2
  AST_STEP_011: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b011) |=> code_q == 3'b101); // R2
  AST_STEP_101: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b101) |=> code_q == 3'b110); // R2
  AST_STEP_110: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b110) |=> code_q == 3'b000); // R2
  AST_ESC_001: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b001) |=> code_q == 3'b110); // R3
  AST_ESC_100: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b100) |=> code_q == 3'b010); // R4
  AST_ESC_111: assert property (@(posedge clk) disable iff (rst) (run && code_q == 3'b111) |=> code_q == 3'b100); // R5
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    legal_q == (code_q == 3'b000 || code_q == 3'b010 || code_q == 3'b011 ||
                code_q == 3'b101 || code_q == 3'b110)); // R7
  AST_BAD_LEAVES: assert property (@(posedge clk) disable iff (rst) (run && !legal_q) |=> (code_q != $past(code_q))); // R8
endmodule

bind cyc5_counter cyc5_counter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .load_code (load_code),
  .code_q    (code_q),
  .legal_q   (legal_q)
);

// File: tb/cyc5_counter_test.sv
module cyc5_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [2:0] load_code = 3'b000;
  logic [2:0] code_q;
  logic       legal_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cyc5_counter uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_code(load_code),
    .code_q(code_q), .legal_q(legal_q)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] exp_code, input logic exp_legal);
    checks++;
    if (code_q !== exp_code || legal_q !== exp_legal) begin
      errors++;
      $display("FAIL %s code=%b legal=%b expected code=%b legal=%b",
               req, code_q, legal_q, exp_code, exp_legal);
    end
  endtask

  task automatic force_code(input logic [2:0] c);
    load_en = 1'b1; load_code = c;
    step();
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    check("R1 reset state", 3'b000, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_loop();
    logic [2:0] seq [5] = '{3'b010, 3'b011, 3'b101, 3'b110, 3'b000};
    t_reset();
    for (int i = 0; i < 5; i++) begin
      step();
      check("R2 loop step", seq[i], 1'b1);
    end
    for (int i = 0; i < 5; i++) step();
    check("R9 period five", 3'b000, 1'b1);
  endtask

  task automatic t_escape(input string req, input logic [2:0] bad,
                          input logic [2:0] e1, input logic l1,
                          input logic [2:0] e2);
    force_code(bad);
    check("R7 illegal flag", bad, 1'b0);
    step();
    check(req, e1, l1);
    step();
    check("R8 back in loop", e2, 1'b1);
  endtask

  task automatic t_load();
    t_reset();
    force_code(3'b101);
    check("R6 load overrides advance", 3'b101, 1'b1);
    step();
    check("R6 advance after load", 3'b110, 1'b1);
  endtask

  task automatic t_reset_prio();
    force_code(3'b011);
    rst = 1'b1; load_en = 1'b1; load_code = 3'b111;
    step();
    rst = 1'b0; load_en = 1'b0;
    check("R1 reset over load", 3'b000, 1'b1);
  endtask

  initial begin
    t_reset();
    t_loop();
    t_escape("R3 001 to 110", 3'b001, 3'b110, 1'b1, 3'b000);
    t_escape("R4 100 to 010", 3'b100, 3'b010, 1'b1, 3'b011);
    t_escape("R5 111 to 100", 3'b111, 3'b100, 1'b0, 3'b010);
    t_load();
    t_reset_prio();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule